// File: doc/BRIEF.md
# Packet-Device Task-File Register Model

This block is the register face that an emulated optical drive shows to a host on a parallel disk bus. It watches the two block selects, the three-bit register address and the read and write strobes. It holds the register set that the packet protocol uses. Several addresses have one register behind a read and a different register behind a write. The block drives the interrupt request line, and it obeys the interrupt-mask and soft-reset bits that the host writes through the control block. The drive answers only when the drive-select register names the drive number taken from the cable-select pin.

Drive firmware uses a small side port. Through it the firmware loads the status, error, interrupt-reason and byte-count values, and it raises an interrupt with a one-cycle pulse. It also receives the host's command writes and the features and byte-count values. Packet decoding, data buffering and DMA live elsewhere.

All host inputs are sampled by the block clock. A write takes effect on the clock edge where the write strobe is first seen high again. A read acknowledge takes effect the same way, on the clock edge where the read strobe is first seen high again.

Top module: `pkt_taskfile`

## Requirements
- R1: With only the command-block select low, reads return these values, zero-extended to 16 bits. Address 1 gives error, address 2 gives interrupt reason, address 4 gives byte count bits 7:0, address 5 gives byte count bits 15:8, address 6 gives drive select and address 7 gives status. Addresses 0 and 3 read as zero.
- R2: Writes to the command block take effect at the end of the write strobe. Address 1 loads features, addresses 4 and 5 load the low and high bytes of the byte count, and address 6 loads drive select. Address 7 produces a one-cycle `cmdStrobe` with `cmdCode` equal to the written byte.
- R3: `hostDoutEn` is high only while `hostRdN` is low and the device is selected. While it is low, `hostDout` is zero.
- R4: A completed status read at command-block address 7 clears the pending interrupt, so `intReq` falls.
- R5: With only the control-block select low, a read at address 6 returns the same value as status and leaves the pending interrupt set.
- R6: Device-control bit 1 masks `intReq` while it is set. A pending interrupt is kept, and `intReq` returns when the bit is cleared.
- R7: A device-control write with bit 2 set, followed by one with bit 2 clear, clears features, byte count and the pending interrupt. Status then reads as 0x80 for `RST_BUSY_CYCLES` clocks, and afterwards shows the firmware value again.
- R8: An access with both selects low or both high changes no register and drives no data.
- R9: The device is selected only when drive-select bit 4 equals `cableSel` (0 for a grounded pin, 1 for an open pin). When it is not selected, no read is driven and no write lands, except writes to drive select and device control.
- R10: A `fwLoad` pulse writes `fwData` into the field chosen by `fwField`: 0 status, 1 error, 2 interrupt reason, 3 the 16-bit byte count.
- R11: `fwIrqPulse` sets the pending interrupt. If it arrives in the same cycle as a status-read acknowledge, the interrupt stays pending.
- R12: After reset every register is zero, `intReq` and `hostDoutEn` are low, and `featuresOut` and `byteCountOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| hostCs0N | input | 1 | Command-block select, active low |
| hostCs1N | input | 1 | Control-block select, active low |
| hostAddr | input | 3 | Register address |
| hostWrN | input | 1 | Write strobe, active low |
| hostRdN | input | 1 | Read strobe, active low |
| hostDin | input | 16 | Data from host |
| hostDout | output | 16 | Data to host |
| hostDoutEn | output | 1 | Drive enable for the data bus |
| intReq | output | 1 | Interrupt request to host |
| cableSel | input | 1 | Own drive number from cable select |
| fwLoad | input | 1 | Firmware register load pulse |
| fwField | input | 2 | Firmware target field |
| fwData | input | 16 | Firmware load data |
| fwIrqPulse | input | 1 | Firmware interrupt pulse |
| cmdStrobe | output | 1 | One-cycle pulse on a host command write |
| cmdCode | output | 8 | Command byte written by host |
| featuresOut | output | 8 | Current features value |
| byteCountOut | output | 16 | Current byte count |

## Verification
The assertions assume that the host strobes and selects are synchronous to `clk`. They also assume that the host holds the select and address stable on the clock edge where a strobe goes high, and that it never pulses read and write together. The bench drives every input on the falling clock edge. It keeps the selects and the address steady for a full cycle after raising a strobe, and it only releases the selects after that cycle. The firmware pulse that collides with an acknowledge is placed on exactly the cycle where the read strobe rises, so the set-over-clear ordering is exercised on purpose.

// File: rtl/pkt_tf_pkg.sv
package pkt_tf_pkg;

  localparam int DATA_W = 16;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;

  localparam int DRV_BIT = 4;
  localparam int NIEN_BIT = 1;
  localparam int SRST_BIT = 2;

  localparam logic [REG_W-1:0] BUSY_STATUS = 8'h80;

  localparam logic [ADDR_W-1:0] A_ERR_FEAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_REASON = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_DRVSEL = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT_CMD = 3'd7;
  localparam logic [ADDR_W-1:0] A_ALT_CTL = 3'd6;

  typedef enum logic [1:0] {
    FW_STATUS = 2'd0,
    FW_ERROR = 2'd1,
    FW_REASON = 2'd2,
    FW_BYTECNT = 2'd3
  } fwFieldE;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ERROR,
    RD_REASON,
    RD_CNTLO,
    RD_CNTHI,
    RD_DRVSEL,
    RD_STATUS
  } rdSelE;

  typedef struct packed {
    logic wrFeat;
    logic wrCmd;
    logic wrCntLo;
    logic wrCntHi;
    logic wrDrvSel;
    logic wrDevCtl;
    logic ackIrq;
    logic srstClear;
    logic busy;
    logic rdEn;
    rdSelE rdSel;
  } tfStrbT;

endpackage

// File: rtl/pkt_tf_ctrl.sv
module pkt_tf_ctrl
  import pkt_tf_pkg::*;
#(
  parameter int RST_BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs0N,
  input  logic              cs1N,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              srstBitIn,
  input  logic              drvSelBit,
  input  logic              cableSel,
  output tfStrbT            strb
);

  localparam int CNT_W = $clog2(RST_BUSY_CYCLES + 1);

  logic prevWrN, prevRdN;
  logic wrEvt, rdEvt;
  logic cmdBlk, ctlBlk, driveMatch;
  logic srstArmed;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWrN <= 1'b1;
      prevRdN <= 1'b1;
    end else begin
      prevWrN <= wrN;
      prevRdN <= rdN;
    end
  end

  assign wrEvt = !prevWrN && wrN;
  assign rdEvt = !prevRdN && rdN;
  assign cmdBlk = !cs0N && cs1N;
  assign ctlBlk = cs0N && !cs1N;
  assign driveMatch = (drvSelBit == cableSel);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (cmdBlk && driveMatch && wrEvt) begin
      strb.wrFeat = (addr == A_ERR_FEAT);
      strb.wrCmd = (addr == A_STAT_CMD);
      strb.wrCntLo = (addr == A_CNT_LO);
      strb.wrCntHi = (addr == A_CNT_HI);
    end
    strb.wrDrvSel = cmdBlk && wrEvt && (addr == A_DRVSEL);
    strb.wrDevCtl = ctlBlk && wrEvt && (addr == A_ALT_CTL);
    strb.ackIrq = cmdBlk && driveMatch && rdEvt && (addr == A_STAT_CMD);
    strb.srstClear = strb.wrDevCtl && !srstBitIn && srstArmed;
    strb.busy = (busyCnt != '0);
    strb.rdEn = !rdN && (cmdBlk || ctlBlk) && driveMatch;
    if (cmdBlk) begin
      unique case (addr)
        A_ERR_FEAT: strb.rdSel = RD_ERROR;
        A_REASON:   strb.rdSel = RD_REASON;
        A_CNT_LO:   strb.rdSel = RD_CNTLO;
        A_CNT_HI:   strb.rdSel = RD_CNTHI;
        A_DRVSEL:   strb.rdSel = RD_DRVSEL;
        A_STAT_CMD: strb.rdSel = RD_STATUS;
        default:    strb.rdSel = RD_NONE;
      endcase
    end else if (ctlBlk && addr == A_ALT_CTL) begin
      strb.rdSel = RD_STATUS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srstArmed <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strb.wrDevCtl) srstArmed <= srstBitIn;
      if (strb.srstClear) busyCnt <= CNT_W'(RST_BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  // R8: with both selects low nothing may fire
  a_r8_both_cs_inert: assert property (@(posedge clk) disable iff (!rstN)
    (!cs0N && !cs1N) |-> !(strb.wrFeat || strb.wrCmd || strb.wrCntLo || strb.wrCntHi ||
                           strb.wrDrvSel || strb.wrDevCtl || strb.ackIrq || strb.rdEn));

  // R7: release of soft reset starts the busy window
  a_r7_busy_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.srstClear |=> strb.busy);

  // R9: a foreign drive number blocks read drive
  a_r9_foreign_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (drvSelBit != cableSel) |-> !strb.rdEn);

  // R2: a command write lands only on the rising edge of the write strobe
  a_r2_cmd_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |-> (wrN && $past(!wrN)));

endmodule

// File: rtl/pkt_tf_dpath.sv
module pkt_tf_dpath
  import pkt_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tfStrbT            strb,
  input  logic [DATA_W-1:0] hostDin,
  input  logic              fwLoad,
  input  logic [1:0]        fwField,
  input  logic [DATA_W-1:0] fwData,
  input  logic              fwIrqPulse,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoutEn,
  output logic              intReq,
  output logic              cmdStrobe,
  output logic [REG_W-1:0]  cmdCode,
  output logic [REG_W-1:0]  featuresOut,
  output logic [DATA_W-1:0] byteCountOut,
  output logic              drvSelBit
);

  logic [REG_W-1:0] statusR, errorR, reasonR, featR, drvSelR;
  logic [DATA_W-1:0] cntR;
  logic nienR, pending;
  logic [REG_W-1:0] statusView, rdByte;
  fwFieldE fwSel;

  assign fwSel = fwFieldE'(fwField);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusR <= '0;
      errorR <= '0;
      reasonR <= '0;
    end else if (fwLoad) begin
      case (fwSel)
        FW_STATUS: statusR <= fwData[REG_W-1:0];
        FW_ERROR:  errorR <= fwData[REG_W-1:0];
        FW_REASON: reasonR <= fwData[REG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featR <= '0;
      cntR <= '0;
      drvSelR <= '0;
      nienR <= 1'b0;
      pending <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdCode <= '0;
    end else begin
      cmdStrobe <= strb.wrCmd;
      if (strb.wrCmd) cmdCode <= hostDin[REG_W-1:0];
      if (strb.wrDrvSel) drvSelR <= hostDin[REG_W-1:0];
      if (strb.wrDevCtl) nienR <= hostDin[NIEN_BIT];

      if (strb.srstClear) featR <= '0;
      else if (strb.wrFeat) featR <= hostDin[REG_W-1:0];

      if (strb.srstClear) cntR <= '0;
      else if (strb.wrCntLo) cntR[REG_W-1:0] <= hostDin[REG_W-1:0];
      else if (strb.wrCntHi) cntR[DATA_W-1:REG_W] <= hostDin[REG_W-1:0];
      else if (fwLoad && fwSel == FW_BYTECNT) cntR <= fwData;

      if (fwIrqPulse) pending <= 1'b1;
      else if (strb.ackIrq || strb.srstClear) pending <= 1'b0;
    end
  end

  assign statusView = strb.busy ? BUSY_STATUS : statusR;

  always_comb begin
    unique case (strb.rdSel)
      RD_ERROR:  rdByte = errorR;
      RD_REASON: rdByte = reasonR;
      RD_CNTLO:  rdByte = cntR[REG_W-1:0];
      RD_CNTHI:  rdByte = cntR[DATA_W-1:REG_W];
      RD_DRVSEL: rdByte = drvSelR;
      RD_STATUS: rdByte = statusView;
      default:   rdByte = '0;
    endcase
  end

  assign hostDoutEn = strb.rdEn;
  assign hostDout = strb.rdEn ? {{(DATA_W-REG_W){1'b0}}, rdByte} : '0;
  assign intReq = pending && !nienR;
  assign featuresOut = featR;
  assign byteCountOut = cntR;
  assign drvSelBit = drvSelR[DRV_BIT];

  // R4: a status-read acknowledge without a new pulse clears the interrupt
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackIrq && !fwIrqPulse) |=> !intReq);

  // R11: the firmware pulse always leaves an interrupt pending
  a_r11_pulse_sets: assert property (@(posedge clk) disable iff (!rstN)
    fwIrqPulse |=> pending);

  // R6: masking keeps the pending condition
  a_r6_mask_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (nienR && pending && !strb.ackIrq && !strb.srstClear) |=> pending);

  // R7: soft reset release empties features, count and interrupt
  a_r7_srst_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.srstClear && !fwIrqPulse) |=> (featuresOut == '0 && byteCountOut == '0 && !intReq));

endmodule

// File: rtl/pkt_taskfile.sv
module pkt_taskfile
  import pkt_tf_pkg::*;
#(
  parameter int RST_BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs0N,
  input  logic              hostCs1N,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoutEn,
  output logic              intReq,
  input  logic              cableSel,
  input  logic              fwLoad,
  input  logic [1:0]        fwField,
  input  logic [DATA_W-1:0] fwData,
  input  logic              fwIrqPulse,
  output logic              cmdStrobe,
  output logic [REG_W-1:0]  cmdCode,
  output logic [REG_W-1:0]  featuresOut,
  output logic [DATA_W-1:0] byteCountOut
);

  tfStrbT strb;
  logic drvSelBit;

  pkt_tf_ctrl #(.RST_BUSY_CYCLES(RST_BUSY_CYCLES)) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .cs0N(hostCs0N),
    .cs1N(hostCs1N),
    .addr(hostAddr),
    .wrN(hostWrN),
    .rdN(hostRdN),
    .srstBitIn(hostDin[SRST_BIT]),
    .drvSelBit(drvSelBit),
    .cableSel(cableSel),
    .strb(strb)
  );

  pkt_tf_dpath dpath_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .hostDin(hostDin),
    .fwLoad(fwLoad),
    .fwField(fwField),
    .fwData(fwData),
    .fwIrqPulse(fwIrqPulse),
    .hostDout(hostDout),
    .hostDoutEn(hostDoutEn),
    .intReq(intReq),
    .cmdStrobe(cmdStrobe),
    .cmdCode(cmdCode),
    .featuresOut(featuresOut),
    .byteCountOut(byteCountOut),
    .drvSelBit(drvSelBit)
  );

endmodule

// File: tb/pkt_taskfile_tb_top.sv
`timescale 1ns/1ps
module pkt_taskfile_tb_top;

  localparam int RST_CYC = 16;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCs0N = 1'b1, hostCs1N = 1'b1;
  logic [2:0] hostAddr = '0;
  logic hostWrN = 1'b1, hostRdN = 1'b1;
  logic [15:0] hostDin = '0;
  logic [15:0] hostDout;
  logic hostDoutEn, intReq;
  logic cableSel = 1'b0;
  logic fwLoad = 1'b0;
  logic [1:0] fwField = '0;
  logic [15:0] fwData = '0;
  logic fwIrqPulse = 1'b0;
  logic cmdStrobe;
  logic [7:0] cmdCode, featuresOut;
  logic [15:0] byteCountOut;

  int checks = 0;
  int errors = 0;
  int cmdSeen = 0;
  logic [7:0] lastCmd = '0;
  logic [15:0] rdVal;
  logic rdEnVal;

  always #4 clk = ~clk;

  pkt_taskfile #(.RST_BUSY_CYCLES(RST_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .hostCs0N(hostCs0N), .hostCs1N(hostCs1N),
    .hostAddr(hostAddr), .hostWrN(hostWrN), .hostRdN(hostRdN), .hostDin(hostDin),
    .hostDout(hostDout), .hostDoutEn(hostDoutEn), .intReq(intReq), .cableSel(cableSel),
    .fwLoad(fwLoad), .fwField(fwField), .fwData(fwData), .fwIrqPulse(fwIrqPulse),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .featuresOut(featuresOut),
    .byteCountOut(byteCountOut)
  );

  always @(posedge clk) begin
    if (cmdStrobe) begin
      cmdSeen <= cmdSeen + 1;
      lastCmd <= cmdCode;
    end
  end

  // op: 0 host write, 1 host read, 2 firmware load (addr carries the field)
  typedef struct packed {
    logic [1:0]  op;
    logic        cs0N;
    logic        cs1N;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] expVal;
    logic        expEn;
    logic [7:0]  req;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{2'd2, 1'b1, 1'b1, 3'd0, 16'h0050, 16'h0000, 1'b0, 8'd10}, // R10 status
    '{2'd2, 1'b1, 1'b1, 3'd1, 16'h0004, 16'h0000, 1'b0, 8'd10}, // R10 error
    '{2'd2, 1'b1, 1'b1, 3'd2, 16'h0003, 16'h0000, 1'b0, 8'd10}, // R10 reason
    '{2'd2, 1'b1, 1'b1, 3'd3, 16'h1234, 16'h0000, 1'b0, 8'd10}, // R10 count
    '{2'd1, 1'b0, 1'b1, 3'd7, 16'h0000, 16'h0050, 1'b1, 8'd1},  // R1 status
    '{2'd1, 1'b0, 1'b1, 3'd1, 16'h0000, 16'h0004, 1'b1, 8'd1},  // R1 error
    '{2'd1, 1'b0, 1'b1, 3'd2, 16'h0000, 16'h0003, 1'b1, 8'd1},  // R1 reason
    '{2'd1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h0034, 1'b1, 8'd1},  // R1 count lo
    '{2'd1, 1'b0, 1'b1, 3'd5, 16'h0000, 16'h0012, 1'b1, 8'd1},  // R1 count hi
    '{2'd1, 1'b0, 1'b1, 3'd3, 16'h0000, 16'h0000, 1'b1, 8'd1},  // R1 unmapped
    '{2'd1, 1'b0, 1'b1, 3'd0, 16'h0000, 16'h0000, 1'b1, 8'd1},  // R1 data port reads 0
    '{2'd0, 1'b0, 1'b1, 3'd1, 16'h00AB, 16'h0000, 1'b0, 8'd2},  // R2 features
    '{2'd0, 1'b0, 1'b1, 3'd4, 16'h00CD, 16'h0000, 1'b0, 8'd2},  // R2 count lo
    '{2'd1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h00CD, 1'b1, 8'd2},  // R2 readback
    '{2'd1, 1'b0, 1'b1, 3'd5, 16'h0000, 16'h0012, 1'b1, 8'd2},  // R2 hi kept
    '{2'd1, 1'b0, 1'b0, 3'd7, 16'h0000, 16'h0000, 1'b0, 8'd8},  // R8 both selects
    '{2'd0, 1'b0, 1'b0, 3'd4, 16'h0077, 16'h0000, 1'b0, 8'd8},  // R8 write both
    '{2'd0, 1'b1, 1'b1, 3'd4, 16'h0066, 16'h0000, 1'b0, 8'd8},  // R8 write neither
    '{2'd1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h00CD, 1'b1, 8'd8},  // R8 unchanged
    '{2'd1, 1'b1, 1'b0, 3'd6, 16'h0000, 16'h0050, 1'b1, 8'd5},  // R5 alt status
    '{2'd0, 1'b0, 1'b1, 3'd6, 16'h0010, 16'h0000, 1'b0, 8'd9},  // R9 select drive 1
    '{2'd1, 1'b0, 1'b1, 3'd7, 16'h0000, 16'h0000, 1'b0, 8'd9},  // R9 not driven
    '{2'd0, 1'b0, 1'b1, 3'd4, 16'h0099, 16'h0000, 1'b0, 8'd9},  // R9 write dropped
    '{2'd0, 1'b0, 1'b1, 3'd6, 16'h0000, 16'h0000, 1'b0, 8'd9},  // R9 back to drive 0
    '{2'd1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h00CD, 1'b1, 8'd9},  // R9 count kept
    '{2'd1, 1'b0, 1'b1, 3'd6, 16'h0000, 16'h0000, 1'b1, 8'd9}   // R9 drive select read
  };

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic c0, input logic c1, input logic [2:0] a,
                           input logic [15:0] d);
    @(negedge clk);
    hostCs0N = c0; hostCs1N = c1; hostAddr = a; hostDin = d; hostWrN = 1'b0;
    @(negedge clk);
    hostWrN = 1'b1;
    @(negedge clk);
    hostCs0N = 1'b1; hostCs1N = 1'b1;
  endtask

  task automatic hostRead(input logic c0, input logic c1, input logic [2:0] a,
                          output logic [15:0] d, output logic en);
    @(negedge clk);
    hostCs0N = c0; hostCs1N = c1; hostAddr = a; hostRdN = 1'b0;
    #1;
    d = hostDout; en = hostDoutEn;
    @(negedge clk);
    hostRdN = 1'b1;
    @(negedge clk);
    hostCs0N = 1'b1; hostCs1N = 1'b1;
  endtask

  task automatic fwWrite(input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    fwLoad = 1'b1; fwField = f; fwData = d;
    @(negedge clk);
    fwLoad = 1'b0;
  endtask

  task automatic fwPulse();
    @(negedge clk);
    fwIrqPulse = 1'b1;
    @(negedge clk);
    fwIrqPulse = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!intReq && !hostDoutEn, "R12 irq/dout", {14'b0, intReq, hostDoutEn}, 16'h0);
    check(featuresOut == 8'h0 && byteCountOut == 16'h0, "R12 regs", byteCountOut, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    hostRead(1'b0, 1'b1, 3'd7, rdVal, rdEnVal);
    check(rdVal == 16'h0, "R12 status zero", rdVal, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      unique case (VECS[i].op)
        2'd0: hostWrite(VECS[i].cs0N, VECS[i].cs1N, VECS[i].addr, VECS[i].data);
        2'd1: begin
          hostRead(VECS[i].cs0N, VECS[i].cs1N, VECS[i].addr, rdVal, rdEnVal);
          check(rdVal == VECS[i].expVal && rdEnVal == VECS[i].expEn,
                $sformatf("R%0d vector %0d", VECS[i].req, i), rdVal, VECS[i].expVal);
        end
        default: fwWrite(VECS[i].addr[1:0], VECS[i].data);
      endcase
    end

    // R2 features and command strobe
    check(featuresOut == 8'hAB, "R2 features", {8'h0, featuresOut}, 16'h00AB);
    hostWrite(1'b0, 1'b1, 3'd7, 16'h00A0);
    @(negedge clk);
    check(cmdSeen == 1 && lastCmd == 8'hA0, "R2 command", {8'h0, lastCmd}, 16'h00A0);

    // R3 no drive while read strobe high
    @(negedge clk);
    hostCs0N = 1'b0; hostAddr = 3'd7;
    #1;
    check(!hostDoutEn && hostDout == 16'h0, "R3 idle strobe", hostDout, 16'h0);
    hostCs0N = 1'b1;

    // R11 pulse sets, R5 alt read keeps, R4 status read clears
    fwPulse();
    check(intReq, "R11 set", {15'b0, intReq}, 16'h1);
    hostRead(1'b1, 1'b0, 3'd6, rdVal, rdEnVal);
    check(intReq, "R5 alt keeps irq", {15'b0, intReq}, 16'h1);
    hostRead(1'b0, 1'b1, 3'd7, rdVal, rdEnVal);
    check(!intReq, "R4 ack clears", {15'b0, intReq}, 16'h0);

    // R6 masking keeps pending
    fwPulse();
    hostWrite(1'b1, 1'b0, 3'd6, 16'h0002);
    check(!intReq, "R6 masked", {15'b0, intReq}, 16'h0);
    hostWrite(1'b1, 1'b0, 3'd6, 16'h0000);
    check(intReq, "R6 unmasked", {15'b0, intReq}, 16'h1);

    // R11 collision: pulse on the acknowledge cycle keeps the interrupt
    @(negedge clk);
    hostCs0N = 1'b0; hostAddr = 3'd7; hostRdN = 1'b0;
    @(negedge clk);
    hostRdN = 1'b1; fwIrqPulse = 1'b1;
    @(negedge clk);
    fwIrqPulse = 1'b0; hostCs0N = 1'b1;
    check(intReq, "R11 set wins", {15'b0, intReq}, 16'h1);

    // R7 soft reset
    hostWrite(1'b1, 1'b0, 3'd6, 16'h0004);
    hostWrite(1'b1, 1'b0, 3'd6, 16'h0000);
    check(featuresOut == 8'h0 && byteCountOut == 16'h0, "R7 cleared", byteCountOut, 16'h0);
    check(!intReq, "R7 irq cleared", {15'b0, intReq}, 16'h0);
    hostRead(1'b1, 1'b0, 3'd6, rdVal, rdEnVal);
    check(rdVal == 16'h0080, "R7 busy", rdVal, 16'h0080);
    repeat (RST_CYC + 2) @(negedge clk);
    hostRead(1'b1, 1'b0, 3'd6, rdVal, rdEnVal);
    check(rdVal == 16'h0050, "R7 busy ends", rdVal, 16'h0050);

    // R9 cable select open gives drive 1
    cableSel = 1'b1;
    hostRead(1'b0, 1'b1, 3'd7, rdVal, rdEnVal);
    check(!rdEnVal, "R9 cable open unselected", {15'b0, rdEnVal}, 16'h0);
    hostWrite(1'b0, 1'b1, 3'd6, 16'h0010);
    hostRead(1'b0, 1'b1, 3'd7, rdVal, rdEnVal);
    check(rdEnVal && rdVal == 16'h0050, "R9 drive 1 selected", rdVal, 16'h0050);

    finishRun();
  end

endmodule